// File: doc/BRIEF.md
# Prescaled Seconds Counter with Alarm

This block is a free-running up-counter that measures whole periods of a slow time base. A strobe input marks each tick of that slow base. The ticks pass through a programmable prescaler, and every time the prescaler wraps, a 32-bit counter advances by one. Set the reload to the tick rate and the counter counts seconds. Software cannot load the counter. It can only restart it, which clears both the prescaler and the counter.

An alarm compare register raises an alarm event when the counter steps onto its value. Every counter step also raises an increment event. Both events are kept as sticky flags in a status word, and reading that word clears it. One level-sensitive interrupt line is driven by the flags whose enables are set in the mode register. The host reaches the four registers over a plain 32-bit register bus with separate read and write strobes. Read data is combinational from the address.

Top module: `secs_timer`

## Requirements
- R1: After reset the mode register reads 0x00008000, the alarm register reads 0xFFFFFFFF, the value and status registers read 0, and `irq` is low.
- R2: Byte offsets are mode 0x0, alarm 0x4, value 0x8 and status 0xC. Mode bits 15:0 are the reload value, bit 16 is the alarm interrupt enable and bit 17 is the increment interrupt enable. Bit 18 always reads 0. Any other offset reads 0.
- R3: With reload N from 1 to 65535, the value register rises by one on every Nth tick after a restart. A reload of 0 means 65536 ticks per step.
- R4: Writes to the value register and to the status register change nothing that a read shows.
- R5: A mode write with bit 18 set zeroes the prescaler and the counter and still stores bits 17:0. A tick in the same cycle as the restart does not count.
- R6: Status bit 1 sets on every counter step. Status bit 0 sets on the step at which the new counter value equals the alarm register.
- R7: A read of the status register returns the flags and clears them. A flag whose event occurs in the same cycle as the read stays set.
- R8: `irq` is high exactly when (status bit 0 and mode bit 16) or (status bit 1 and mode bit 17) is true.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Host clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_tick | input | 1 | One-cycle strobe per slow time base tick |
| bus_addr | input | 4 | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; a status read clears the flags |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq | output | 1 | Level interrupt from the enabled flags |

## Verification
The bench builds the block with its default parameters: a 16-bit prescaler, a 32-bit counter, a 32-bit data bus and a 4-bit address. Small reload values of 1 and 3 keep the step, alarm and interrupt sequences short. The reload of zero runs the full 65536-tick period, so the prescaler's wrap at its maximum width is actually reached. The 32-bit counter wrap is out of reach at this width. The counter's step assertion covers it structurally instead.

// File: rtl/secs_timer_pkg.sv
package secs_timer_pkg;

    localparam int unsigned DEF_PRE_W  = 16;
    localparam int unsigned DEF_CNT_W  = 32;
    localparam int unsigned DEF_DATA_W = 32;
    localparam int unsigned DEF_ADDR_W = 4;

    typedef enum logic [1:0] {
        REG_MODE   = 2'd0,
        REG_ALARM  = 2'd1,
        REG_VALUE  = 2'd2,
        REG_STATUS = 2'd3
    } reg_sel_e;

    // interrupt enables, packed so inc_ie is the upper bit
    typedef struct packed {
        logic inc_ie;
        logic alm_ie;
    } irq_en_t;

    // sticky flags; alm is bit 0, inc is bit 1
    typedef struct packed {
        logic inc;
        logic alm;
    } evt_t;

    typedef struct packed {
        logic     valid;
        reg_sel_e sel;
    } decode_t;

    function automatic decode_t decode_addr(input logic [31:0] a);
        decode_t d;
        d.valid = (a[31:4] == 28'd0) && (a[1:0] == 2'b00);
        d.sel   = reg_sel_e'(a[3:2]);
        return d;
    endfunction

    function automatic logic irq_level(input evt_t s, input irq_en_t e);
        return (s.alm & e.alm_ie) | (s.inc & e.inc_ie);
    endfunction

endpackage

// File: rtl/secs_timer_prescaler.sv
module secs_timer_prescaler #(
    parameter int unsigned PRE_W = secs_timer_pkg::DEF_PRE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             tick,
    input  logic [PRE_W-1:0] reload,
    output logic             step
);
    logic [PRE_W-1:0] phase_q;
    logic [PRE_W-1:0] terminal;

    // reload - 1 in PRE_W bits: a reload of 0 wraps to all-ones, i.e. 2**PRE_W ticks
    assign terminal = reload - PRE_W'(1);
    assign step     = tick && !restart && (phase_q == terminal);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            phase_q <= '0;
        end else if (tick) begin
            phase_q <= (phase_q == terminal) ? '0 : phase_q + PRE_W'(1);
        end
    end
endmodule

// File: rtl/secs_timer_counter.sv
module secs_timer_counter #(
    parameter int unsigned CNT_W = secs_timer_pkg::DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             step,
    input  logic [CNT_W-1:0] alarm,
    output logic [CNT_W-1:0] count,
    output logic             alarm_hit
);
    logic [CNT_W-1:0] count_nx;

    assign count_nx  = count + CNT_W'(1);
    assign alarm_hit = step && (count_nx == alarm);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            count <= '0;
        end else if (step) begin
            count <= count_nx;
        end
    end
endmodule

// File: rtl/secs_timer_regs.sv
module secs_timer_regs
    import secs_timer_pkg::*;
#(
    parameter int unsigned PRE_W  = DEF_PRE_W,
    parameter int unsigned CNT_W  = DEF_CNT_W,
    parameter int unsigned DATA_W = DEF_DATA_W,
    parameter int unsigned ADDR_W = DEF_ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [CNT_W-1:0]  count,
    input  logic              step,
    input  logic              alarm_hit,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              restart,
    output logic [PRE_W-1:0]  reload,
    output logic [CNT_W-1:0]  alarm,
    output evt_t              flags,
    output irq_en_t           enables
);
    localparam int unsigned ALM_IE_BIT  = PRE_W;
    localparam int unsigned INC_IE_BIT  = PRE_W + 1;
    localparam int unsigned RESTART_BIT = PRE_W + 2;
    localparam int unsigned MODE_W      = PRE_W + 2;
    localparam logic [PRE_W-1:0] RELOAD_RST = {1'b1, {(PRE_W-1){1'b0}}};

    decode_t dec;
    logic    wr_mode, wr_alarm, rd_status;
    evt_t    flags_nx;

    assign dec       = decode_addr(32'(bus_addr));
    assign wr_mode   = bus_wr && dec.valid && (dec.sel == REG_MODE);
    assign wr_alarm  = bus_wr && dec.valid && (dec.sel == REG_ALARM);
    assign rd_status = bus_rd && dec.valid && (dec.sel == REG_STATUS);
    assign restart   = wr_mode && bus_wdata[RESTART_BIT];

    logic unused_wdata_hi;
    generate
        if (DATA_W > RESTART_BIT + 1) begin : g_unused_hi
            assign unused_wdata_hi = ^bus_wdata[DATA_W-1:RESTART_BIT+1];
        end else begin : g_no_hi
            assign unused_wdata_hi = 1'b0;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            reload  <= RELOAD_RST;
            enables <= '0;
        end else if (wr_mode) begin
            reload         <= bus_wdata[PRE_W-1:0];
            enables.alm_ie <= bus_wdata[ALM_IE_BIT];
            enables.inc_ie <= bus_wdata[INC_IE_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            alarm <= '1;
        end else if (wr_alarm) begin
            alarm <= bus_wdata[CNT_W-1:0];
        end
    end

    // an event in the same cycle as a clearing read keeps its flag
    always_comb begin
        flags_nx.alm = alarm_hit | (flags.alm & ~rd_status);
        flags_nx.inc = step      | (flags.inc & ~rd_status);
    end

    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= flags_nx;
    end

    always_comb begin
        bus_rdata = '0;
        if (dec.valid) begin
            unique case (dec.sel)
                REG_MODE:   bus_rdata = DATA_W'({enables, reload});
                REG_ALARM:  bus_rdata = DATA_W'(alarm);
                REG_VALUE:  bus_rdata = DATA_W'(count);
                REG_STATUS: bus_rdata = DATA_W'(flags);
                default:    bus_rdata = '0;
            endcase
        end
    end

    assign irq = irq_level(flags, enables);

    initial begin
        if (DATA_W < MODE_W + 1 || DATA_W < CNT_W) $error("bus too narrow for the mode or count fields");
    end
endmodule

// File: rtl/secs_timer.sv
module secs_timer
    import secs_timer_pkg::*;
#(
    parameter int unsigned PRE_W  = DEF_PRE_W,
    parameter int unsigned CNT_W  = DEF_CNT_W,
    parameter int unsigned DATA_W = DEF_DATA_W,
    parameter int unsigned ADDR_W = DEF_ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              slow_tick,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    logic             restart, step, alarm_hit;
    logic [PRE_W-1:0] reload;
    logic [CNT_W-1:0] count_q, alarm_q;
    evt_t             flags_q;
    irq_en_t          enables_q;

    secs_timer_prescaler #(.PRE_W(PRE_W)) u_presc (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .tick    (slow_tick),
        .reload  (reload),
        .step    (step)
    );

    secs_timer_counter #(.CNT_W(CNT_W)) u_count (
        .clk       (clk),
        .rst       (rst),
        .restart   (restart),
        .step      (step),
        .alarm     (alarm_q),
        .count     (count_q),
        .alarm_hit (alarm_hit)
    );

    secs_timer_regs #(
        .PRE_W (PRE_W),
        .CNT_W (CNT_W),
        .DATA_W(DATA_W),
        .ADDR_W(ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .count     (count_q),
        .step      (step),
        .alarm_hit (alarm_hit),
        .bus_rdata (bus_rdata),
        .irq       (irq),
        .restart   (restart),
        .reload    (reload),
        .alarm     (alarm_q),
        .flags     (flags_q),
        .enables   (enables_q)
    );
endmodule

// File: rtl/secs_timer_checker.sv
module secs_timer_checker #(
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned ADDR_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              tick,
    input logic [ADDR_W-1:0] addr,
    input logic              wr,
    input logic              rd,
    input logic              restart_bit,
    input logic              rdata_b18,
    input logic              irq,
    input logic [CNT_W-1:0]  count,
    input logic [CNT_W-1:0]  alarm,
    input logic [1:0]        flags
);
    logic is_mode, is_status;
    assign is_mode   = (addr == ADDR_W'(0));
    assign is_status = (addr == ADDR_W'(12));

    // R2: the restart bit never reads back
    assert_restart_reads_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (rd && is_mode) |-> !rdata_b18);

    // R3: the counter only steps by one or returns to zero
    assert_count_steps_R3: assert property (@(posedge clk) disable iff (rst)
        (count != $past(count)) |-> (count == $past(count) + CNT_W'(1) || count == '0));

    // R5: restart write zeroes the counter
    assert_restart_clears_R5: assert property (@(posedge clk) disable iff (rst)
        (wr && is_mode && restart_bit) |=> (count == '0));

    // R6: stepping onto the alarm value raises the alarm flag
    assert_alarm_flag_R6: assert property (@(posedge clk) disable iff (rst)
        (count != $past(count) && count != '0 && count == $past(alarm)) |-> flags[0]);

    // R7: a status read with no tick leaves no flag behind
    assert_read_clears_R7: assert property (@(posedge clk) disable iff (rst)
        (rd && is_status && !tick) |=> (flags == 2'b00));

    // R8: no flag, no interrupt
    assert_irq_needs_flag_R8: assert property (@(posedge clk) disable iff (rst)
        (flags == 2'b00) |-> !irq);
endmodule

bind secs_timer secs_timer_checker #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_checker (
    .clk         (clk),
    .rst         (rst),
    .tick        (slow_tick),
    .addr        (bus_addr),
    .wr          (bus_wr),
    .rd          (bus_rd),
    .restart_bit (bus_wdata[PRE_W+2]),
    .rdata_b18   (bus_rdata[PRE_W+2]),
    .irq         (irq),
    .count       (count_q),
    .alarm       (alarm_q),
    .flags       (flags_q)
);

// File: tb/secs_timer_bench.sv
module secs_timer_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        slow_tick = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    secs_timer u_secs_timer (
        .clk       (clk),
        .rst       (rst),
        .slow_tick (slow_tick),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    typedef struct packed {
        logic        wr;
        logic [3:0]  addr;
        logic [31:0] data;
        logic [31:0] expect_v;
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 14;
    localparam vec_t VEC [NVEC] = '{
        '{1'b0, 4'h0, 32'h0,        32'h0000_8000, 4'd1},  // R1 mode reset
        '{1'b0, 4'h4, 32'h0,        32'hFFFF_FFFF, 4'd1},  // R1 alarm reset
        '{1'b0, 4'h8, 32'h0,        32'h0,         4'd1},  // R1 value reset
        '{1'b0, 4'hC, 32'h0,        32'h0,         4'd1},  // R1 status reset
        '{1'b1, 4'h0, 32'h0004_0003, 32'h0,        4'd5},  // restart, reload 3
        '{1'b0, 4'h0, 32'h0,        32'h0000_0003, 4'd2},  // R2 bit 18 reads 0
        '{1'b1, 4'h4, 32'h0000_0005, 32'h0,        4'd2},
        '{1'b0, 4'h4, 32'h0,        32'h0000_0005, 4'd2},  // R2 alarm offset
        '{1'b1, 4'h8, 32'h0000_1234, 32'h0,        4'd4},
        '{1'b0, 4'h8, 32'h0,        32'h0,         4'd4},  // R4 value not loaded
        '{1'b1, 4'hC, 32'h0000_0003, 32'h0,        4'd4},
        '{1'b0, 4'hC, 32'h0,        32'h0,         4'd4},  // R4 status not written
        '{1'b0, 4'h2, 32'h0,        32'h0,         4'd2},  // R2 unmapped
        '{1'b0, 4'hE, 32'h0,        32'h0,         4'd2}   // R2 unmapped
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
        end
    endtask

    // one bus cycle; data sampled mid-cycle, before the edge that acts on it
    task automatic cyc(input logic wr, input logic rd, input logic [3:0] a,
                       input logic [31:0] d, input logic tk, output logic [31:0] q);
        @(negedge clk);
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d; slow_tick = tk;
        #5 q = bus_rdata;
        @(posedge clk);
        #1;
        bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0; slow_tick = 1'b0;
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
        logic [31:0] q;
        cyc(1'b1, 1'b0, a, d, 1'b0, q);
    endtask

    task automatic rd_reg(input logic [3:0] a, output logic [31:0] q);
        cyc(1'b0, 1'b1, a, 32'h0, 1'b0, q);
    endtask

    task automatic ticks(input int n);
        logic [31:0] q;
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 4'h0, 32'h0, 1'b1, q);
    endtask

    task automatic irq_now(input string req, input logic exp_v);
        @(negedge clk);
        #5 check(req, {31'h0, irq}, {31'h0, exp_v});
    endtask

    initial begin
        logic [31:0] q;
        repeat (5) @(posedge clk);
        #1 rst = 1'b0;

        irq_now("R1 irq low after reset", 1'b0);

        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i].wr) begin
                wr_reg(VEC[i].addr, VEC[i].data);
            end else begin
                rd_reg(VEC[i].addr, q);
                check($sformatf("R%0d vector %0d", VEC[i].req, i), q, VEC[i].expect_v);
            end
        end

        // R3 prescaler period 3
        ticks(2);
        rd_reg(4'h8, q); check("R3 no step before 3 ticks", q, 32'd0);
        ticks(1);
        rd_reg(4'h8, q); check("R3 step at third tick", q, 32'd1);
        rd_reg(4'hC, q); check("R6 increment flag", q, 32'd2);
        rd_reg(4'hC, q); check("R7 cleared by read", q, 32'd0);

        // R8 increment interrupt
        wr_reg(4'h0, 32'h0002_0003);
        irq_now("R8 enabled but no flag", 1'b0);
        ticks(3);
        irq_now("R8 increment irq", 1'b1);
        rd_reg(4'hC, q); check("R6 increment flag again", q, 32'd2);
        irq_now("R8 irq drops after read", 1'b0);

        // R6 alarm at value 5, only alarm interrupt enabled
        wr_reg(4'h0, 32'h0001_0003);
        ticks(3);
        irq_now("R8 increment flag masked", 1'b0);
        rd_reg(4'h8, q); check("R3 value 3", q, 32'd3);
        rd_reg(4'hC, q); check("R6 no alarm before match", q, 32'd2);
        ticks(6);
        irq_now("R8 alarm irq", 1'b1);
        rd_reg(4'h8, q); check("R3 value 5", q, 32'd5);
        rd_reg(4'hC, q); check("R6 alarm and increment", q, 32'd3);
        ticks(3);
        rd_reg(4'hC, q); check("R6 alarm only on match", q, 32'd2);

        // R7 event in the same cycle as the clearing read
        wr_reg(4'h0, 32'h0004_0001);
        rd_reg(4'hC, q);
        cyc(1'b0, 1'b1, 4'hC, 32'h0, 1'b1, q);
        check("R7 read before event", q, 32'd0);
        rd_reg(4'hC, q); check("R7 event wins over read", q, 32'd2);
        rd_reg(4'h8, q); check("R3 reload 1 steps each tick", q, 32'd1);

        // R5 restart together with a tick
        cyc(1'b1, 1'b0, 4'h0, 32'h0004_0001, 1'b1, q);
        rd_reg(4'h8, q); check("R5 restart beats tick", q, 32'd0);
        rd_reg(4'h0, q); check("R5 fields stored on restart", q, 32'h0000_0001);
        ticks(1);
        rd_reg(4'h8, q); check("R5 counting resumes", q, 32'd1);

        // R3 reload 0 means 65536
        wr_reg(4'h0, 32'h0004_0000);
        ticks(65535);
        rd_reg(4'h8, q); check("R3 reload 0 not yet", q, 32'd0);
        ticks(1);
        rd_reg(4'h8, q); check("R3 reload 0 wraps at 65536", q, 32'd1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule